// File: doc/BRIEF.md
# Divergence Reconvergence Stack for a Lockstep Thread Group

This block keeps the control-flow state of one group of threads that share a single program counter. It holds a small stack. Each level of the stack stores a resume PC, a join PC and a thread mask. The group always runs at the resume PC of the top level, and only the threads in that level's mask are enabled. The PC and mask the block presents are what the fetch stage uses to issue the group's next instruction.

Two kinds of event update the stack. The first is a step: a non-branch instruction has completed, and the group moves to the supplied PC. The second is a resolved branch, which supplies a per-thread taken mask, the taken target, the fall-through PC and the join PC where the two paths meet again. If the branch splits the enabled threads, the level being executed is parked at the join PC and one level is stacked for each path. The not-taken path is stacked first, so the taken path runs first. A level is removed when its threads reach its join PC, and execution then resumes with the level below. The bottom level has no join PC and is never removed. The join PCs come from an outside analysis; this block only consumes them.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the block presents PC BOOT_PC, a mask with every thread bit set, and overflow_err low.
- R2: A step event (step_valid high, br_valid low) moves the presented PC to step_pc on the next cycle and leaves the mask unchanged, unless that PC equals the top level's join PC.
- R3: A branch whose effective taken mask equals the enabled mask moves the PC to br_target. A branch whose effective taken mask is all zeros moves the PC to br_fallthru. Neither case changes the mask or stacks a level.
- R4: A branch that splits the enabled threads presents br_target on the next cycle. The mask is then the effective taken mask, which is the taken path.
- R5: When the taken path steps to the join PC, its level is removed, and the block presents br_fallthru with the not-taken threads (the enabled threads minus the taken ones).
- R6: When the not-taken path also reaches the join PC, the block presents the join PC with the mask that was enabled before the branch.
- R7: A path whose start PC equals the join PC gets no level of its own. Its threads wait inside the parked level. A branch with both start PCs equal to the join PC acts as a uniform branch to the join PC.
- R8: If a splitting branch has the same join PC as the top level, and the stack holds more than the bottom level, the two new levels replace the top level instead of stacking above it.
- R9: A splitting branch that would need more than DEPTH levels leaves the stack, PC and mask untouched. It sets overflow_err, which stays high until reset.
- R10: When br_valid and step_valid are both high, the branch is applied and step_pc is ignored.
- R11: Taken-mask bits of threads outside the enabled mask are ignored. The effective taken mask is br_taken_mask AND the enabled mask.
- R12: With only the bottom level present, a step to any PC just moves the PC. The level is never removed, and its mask stays at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A resolved branch is presented this cycle |
| br_taken_mask | input | WARP_W | Per-thread taken outcome, bit i for thread i |
| br_target | input | PC_W | Taken destination |
| br_fallthru | input | PC_W | Not-taken destination |
| br_reconv | input | PC_W | Join PC of the two paths |
| step_valid | input | 1 | A non-branch instruction completed |
| step_pc | input | PC_W | PC the group moves to after that instruction |
| fetch_pc | output | PC_W | PC of the group's next instruction |
| active_mask | output | WARP_W | Enabled threads for that instruction |
| overflow_err | output | 1 | Sticky flag for a refused split |

## Verification
Every result of an event sampled at a rising edge appears on fetch_pc, active_mask and overflow_err right after that same edge: there is exactly one register stage and no further delay, and a removal completes in that same cycle. Inputs are driven on the falling edge. A behavioural model of the stack is advanced just after each rising edge and compared with the outputs at the following falling edge on every cycle. Directed checks at the same sample points cover each splitting, removal, replacement and overflow case.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  // Kind of update applied to the stack in one cycle
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_STEP  = 2'd1,
    EV_SPLIT = 2'd2
  } rcs_ev_e;
endpackage

// File: rtl/rcs_branch_eval.sv
module rcs_branch_eval #(
  parameter int WARP_W = 4,
  parameter int PC_W   = 8
) (
  input  logic [WARP_W-1:0] act_mask,
  input  logic [WARP_W-1:0] taken_mask,
  input  logic [PC_W-1:0]   target,
  input  logic [PC_W-1:0]   fallthru,
  input  logic [PC_W-1:0]   reconv,
  output logic              is_split,
  output logic [PC_W-1:0]   uni_pc,
  output logic [WARP_W-1:0] tk_mask,
  output logic [WARP_W-1:0] nt_mask,
  output logic              tk_push,
  output logic              nt_push,
  output logic [1:0]        n_push
);
  logic both_at_join;

  always_comb begin
    tk_mask      = taken_mask & act_mask;
    nt_mask      = act_mask & ~tk_mask;
    both_at_join = (target == reconv) && (fallthru == reconv);
    is_split     = (tk_mask != '0) && (tk_mask != act_mask) && !both_at_join;
    if (tk_mask == '0)           uni_pc = fallthru;
    else if (tk_mask == act_mask) uni_pc = target;
    else                          uni_pc = reconv;
    tk_push = (target != reconv);
    nt_push = (fallthru != reconv);
    n_push  = {1'b0, tk_push} + {1'b0, nt_push};
  end
endmodule

// File: rtl/rcs_stack_store.sv
module rcs_stack_store #(
  parameter int              WARP_W  = 4,
  parameter int              PC_W    = 8,
  parameter int              DEPTH   = 8,
  parameter logic [PC_W-1:0] BOOT_PC = '0,
  localparam int             IW      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IW-1:0]     rd_idx,
  output logic [PC_W-1:0]   rd_next,
  output logic [PC_W-1:0]   rd_rpc,
  output logic [WARP_W-1:0] rd_mask,
  input  logic              nx_we,
  input  logic [IW-1:0]     nx_idx,
  input  logic [PC_W-1:0]   nx_val,
  input  logic              pa_we,
  input  logic [IW-1:0]     pa_idx,
  input  logic [PC_W-1:0]   pa_next,
  input  logic [PC_W-1:0]   pa_rpc,
  input  logic [WARP_W-1:0] pa_mask,
  input  logic              pb_we,
  input  logic [IW-1:0]     pb_idx,
  input  logic [PC_W-1:0]   pb_next,
  input  logic [PC_W-1:0]   pb_rpc,
  input  logic [WARP_W-1:0] pb_mask
);
  logic [PC_W-1:0]   next_q [DEPTH];
  logic [PC_W-1:0]   rpc_q  [DEPTH];
  logic [WARP_W-1:0] mask_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic              en;
    logic [PC_W-1:0]   next_d;
    logic [PC_W-1:0]   rpc_d;
    logic [WARP_W-1:0] mask_d;

    always_comb begin
      en     = 1'b0;
      next_d = next_q[i];
      rpc_d  = rpc_q[i];
      mask_d = mask_q[i];
      if (pa_we && (pa_idx == IW'(i))) begin
        en = 1'b1; next_d = pa_next; rpc_d = pa_rpc; mask_d = pa_mask;
      end else if (pb_we && (pb_idx == IW'(i))) begin
        en = 1'b1; next_d = pb_next; rpc_d = pb_rpc; mask_d = pb_mask;
      end else if (nx_we && (nx_idx == IW'(i))) begin
        en = 1'b1; next_d = nx_val;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        next_q[i] <= (i == 0) ? BOOT_PC : '0;
        rpc_q[i]  <= '0;
        mask_q[i] <= (i == 0) ? {WARP_W{1'b1}} : '0;
      end else if (en) begin
        next_q[i] <= next_d;
        rpc_q[i]  <= rpc_d;
        mask_q[i] <= mask_d;
      end
    end
  end

  assign rd_next = next_q[rd_idx];
  assign rd_rpc  = rpc_q[rd_idx];
  assign rd_mask = mask_q[rd_idx];
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import rcs_pkg::*;
#(
  parameter int              WARP_W  = 4,
  parameter int              PC_W    = 8,
  parameter int              DEPTH   = 8,
  parameter logic [PC_W-1:0] BOOT_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic [WARP_W-1:0] br_taken_mask,
  input  logic [PC_W-1:0]   br_target,
  input  logic [PC_W-1:0]   br_fallthru,
  input  logic [PC_W-1:0]   br_reconv,
  input  logic              step_valid,
  input  logic [PC_W-1:0]   step_pc,
  output logic [PC_W-1:0]   fetch_pc,
  output logic [WARP_W-1:0] active_mask,
  output logic              overflow_err
);
  localparam int IW = $clog2(DEPTH);
  localparam int DW = $clog2(DEPTH + 1);
  localparam int EW = DW + 1;

  logic [DW-1:0]     depth_q, depth_d;
  logic              ovf_q, ovf_d;
  logic [IW-1:0]     top_idx;
  logic [PC_W-1:0]   top_next, top_rpc;
  logic [WARP_W-1:0] top_mask;

  logic              is_split, tk_push, nt_push;
  logic [1:0]        n_push;
  logic [PC_W-1:0]   uni_pc, move_pc;
  logic [WARP_W-1:0] tk_mask, nt_mask;

  rcs_ev_e           ev;
  logic              merge, ovf_now, pop_now;
  logic [EW-1:0]     base, new_depth;

  logic              nx_we, pa_we, pb_we;
  logic [IW-1:0]     nx_idx, pa_idx, pb_idx;
  logic [PC_W-1:0]   nx_val, pa_next, pb_next;
  logic [WARP_W-1:0] pa_mask, pb_mask;

  assign top_idx = IW'(depth_q - DW'(1));

  rcs_branch_eval #(.WARP_W(WARP_W), .PC_W(PC_W)) u_eval (
    .act_mask   (top_mask),
    .taken_mask (br_taken_mask),
    .target     (br_target),
    .fallthru   (br_fallthru),
    .reconv     (br_reconv),
    .is_split   (is_split),
    .uni_pc     (uni_pc),
    .tk_mask    (tk_mask),
    .nt_mask    (nt_mask),
    .tk_push    (tk_push),
    .nt_push    (nt_push),
    .n_push     (n_push)
  );

  rcs_stack_store #(.WARP_W(WARP_W), .PC_W(PC_W), .DEPTH(DEPTH), .BOOT_PC(BOOT_PC)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (top_idx),
    .rd_next (top_next),
    .rd_rpc  (top_rpc),
    .rd_mask (top_mask),
    .nx_we   (nx_we),
    .nx_idx  (nx_idx),
    .nx_val  (nx_val),
    .pa_we   (pa_we),
    .pa_idx  (pa_idx),
    .pa_next (pa_next),
    .pa_rpc  (br_reconv),
    .pa_mask (pa_mask),
    .pb_we   (pb_we),
    .pb_idx  (pb_idx),
    .pb_next (pb_next),
    .pb_rpc  (br_reconv),
    .pb_mask (pb_mask)
  );

  // Event decode: a branch outranks a step in the same cycle
  always_comb begin
    if (br_valid)        ev = is_split ? EV_SPLIT : EV_STEP;
    else if (step_valid) ev = EV_STEP;
    else                 ev = EV_NONE;
    move_pc   = br_valid ? uni_pc : step_pc;
    merge     = (depth_q > DW'(1)) && (br_reconv == top_rpc);
    base      = merge ? (EW'(depth_q) - EW'(1)) : EW'(depth_q);
    new_depth = base + EW'(n_push);
    ovf_now   = (ev == EV_SPLIT) && (new_depth > EW'(DEPTH));
    pop_now   = (ev == EV_STEP) && (depth_q > DW'(1)) && (move_pc == top_rpc);
  end

  // Next-state for the stack contents, depth and error flag
  always_comb begin
    depth_d = depth_q;
    ovf_d   = ovf_q | ovf_now;
    nx_we   = 1'b0; nx_idx = top_idx;       nx_val  = move_pc;
    pa_we   = 1'b0; pa_idx = IW'(base);     pa_next = br_fallthru; pa_mask = nt_mask;
    pb_we   = 1'b0; pb_idx = IW'(base + EW'(1)); pb_next = br_target; pb_mask = tk_mask;
    if (!nt_push) begin
      pa_next = br_target;
      pa_mask = tk_mask;
    end
    case (ev)
      EV_SPLIT: begin
        if (!ovf_now) begin
          nx_we   = !merge;
          nx_val  = br_reconv;
          pa_we   = 1'b1;
          pb_we   = (n_push == 2'd2);
          depth_d = DW'(new_depth);
        end
      end
      EV_STEP: begin
        if (pop_now) depth_d = depth_q - DW'(1);
        else         nx_we   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= DW'(1);
      ovf_q   <= 1'b0;
    end else begin
      depth_q <= depth_d;
      ovf_q   <= ovf_d;
    end
  end

  assign fetch_pc     = top_next;
  assign active_mask  = top_mask;
  assign overflow_err = ovf_q;

  // R4
  mask_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_mask != '0);

  // R4
  split_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_SPLIT && !ovf_now) |=> ((active_mask & ~$past(active_mask)) == '0));

  // R12
  bottom_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_q == DW'(1)) |-> (active_mask == {WARP_W{1'b1}}));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err |=> overflow_err);

  // R9
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_now |=> ($stable(fetch_pc) && $stable(active_mask)));

  // R2
  step_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && !br_valid && !pop_now) |=> (fetch_pc == $past(step_pc) && $stable(active_mask)));
endmodule

// File: tb/simt_reconv_stack_tb.sv
module simt_reconv_stack_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 4;
  localparam int PW  = 8;
  localparam int DEP = 4;
  localparam logic [PW-1:0] BOOT = 8'h10;

  typedef struct {
    logic [PW-1:0] rpc;
    logic [PW-1:0] nxt;
    logic [W-1:0]  m;
  } ent_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic br_valid = 1'b0;
  logic [W-1:0] br_taken_mask = '0;
  logic [PW-1:0] br_target = '0, br_fallthru = '0, br_reconv = '0;
  logic step_valid = 1'b0;
  logic [PW-1:0] step_pc = '0;
  logic [PW-1:0] fetch_pc;
  logic [W-1:0] active_mask;
  logic overflow_err;

  int total = 0;
  int bad = 0;
  bit live = 1'b0;
  bit finished = 1'b0;
  string cur_req = "R1";
  ent_t q[$];
  logic m_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  simt_reconv_stack #(.WARP_W(W), .PC_W(PW), .DEPTH(DEP), .BOOT_PC(BOOT)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .br_valid(br_valid), .br_taken_mask(br_taken_mask), .br_target(br_target),
    .br_fallthru(br_fallthru), .br_reconv(br_reconv),
    .step_valid(step_valid), .step_pc(step_pc),
    .fetch_pc(fetch_pc), .active_mask(active_mask), .overflow_err(overflow_err)
  );

  task automatic model_reset();
    ent_t b;
    b.rpc = '0; b.nxt = BOOT; b.m = '1;
    q = {};
    q.push_back(b);
    m_err = 1'b0;
  endtask

  // Behavioural model of the requirements
  task automatic model_apply(input logic bv, input logic [W-1:0] tm, input logic [PW-1:0] tg,
                             input logic [PW-1:0] ft, input logic [PW-1:0] rp,
                             input logic sv, input logic [PW-1:0] sp);
    ent_t top, e;
    logic [W-1:0] act, tk, nt;
    logic [PW-1:0] npc;
    bit move, merge;
    int n, newsize;
    top = q[q.size()-1];
    act = top.m;
    tk = tm & act;
    nt = act & ~tk;
    move = 1'b0;
    npc = sp;
    if (bv) begin
      if (tk == '0) begin move = 1'b1; npc = ft; end
      else if (tk == act) begin move = 1'b1; npc = tg; end
      else if (tg == rp && ft == rp) begin move = 1'b1; npc = rp; end
      else begin
        merge = (q.size() > 1) && (rp == top.rpc);
        n = int'(ft != rp) + int'(tg != rp);
        newsize = (merge ? q.size() - 1 : q.size()) + n;
        if (newsize > DEP) m_err = 1'b1;
        else begin
          if (merge) void'(q.pop_back());
          else q[q.size()-1].nxt = rp;
          if (ft != rp) begin e.rpc = rp; e.nxt = ft; e.m = nt; q.push_back(e); end
          if (tg != rp) begin e.rpc = rp; e.nxt = tg; e.m = tk; q.push_back(e); end
        end
      end
    end else if (sv) begin
      move = 1'b1;
    end
    if (move) begin
      if (q.size() > 1 && npc == top.rpc) void'(q.pop_back());
      else q[q.size()-1].nxt = npc;
    end
  endtask

  // Per-cycle comparison with the model
  always @(negedge clk) begin
    if (live && !finished) begin
      total++;
      if (fetch_pc !== q[q.size()-1].nxt || active_mask !== q[q.size()-1].m || overflow_err !== m_err) begin
        bad++;
        $display("FAIL %s model: pc=%h mask=%b err=%b expected pc=%h mask=%b err=%b", cur_req,
                 fetch_pc, active_mask, overflow_err, q[q.size()-1].nxt, q[q.size()-1].m, m_err);
      end
    end
  end

  task automatic chk(input string req, input logic [PW-1:0] pe, input logic [W-1:0] me, input logic ee);
    total++;
    if (fetch_pc !== pe || active_mask !== me || overflow_err !== ee) begin
      bad++;
      $display("FAIL %s: pc=%h mask=%b err=%b expected pc=%h mask=%b err=%b",
               req, fetch_pc, active_mask, overflow_err, pe, me, ee);
    end
  endtask

  task automatic ev(input logic bv, input logic [W-1:0] tm, input logic [PW-1:0] tg,
                    input logic [PW-1:0] ft, input logic [PW-1:0] rp,
                    input logic sv, input logic [PW-1:0] sp);
    br_valid = bv; br_taken_mask = tm; br_target = tg; br_fallthru = ft; br_reconv = rp;
    step_valid = sv; step_pc = sp;
    @(posedge clk);
    #1;
    model_apply(bv, tm, tg, ft, rp, sv, sp);
    br_valid = 1'b0; step_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic br(input logic [W-1:0] tm, input logic [PW-1:0] tg,
                    input logic [PW-1:0] ft, input logic [PW-1:0] rp);
    ev(1'b1, tm, tg, ft, rp, 1'b0, '0);
  endtask

  task automatic st(input logic [PW-1:0] sp);
    ev(1'b0, '0, '0, '0, '0, 1'b1, sp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live = 1'b1;
    #1;
    chk("R1", BOOT, 4'b1111, 1'b0);

    cur_req = "R2";
    st(8'h11); chk("R2", 8'h11, 4'b1111, 1'b0);
    st(8'h12); chk("R2", 8'h12, 4'b1111, 1'b0);

    cur_req = "R3";
    br(4'b1111, 8'h20, 8'h13, 8'h30); chk("R3", 8'h20, 4'b1111, 1'b0);
    br(4'b0000, 8'h50, 8'h21, 8'h30); chk("R3", 8'h21, 4'b1111, 1'b0);

    cur_req = "R4";
    br(4'b0101, 8'h30, 8'h22, 8'h40); chk("R4", 8'h30, 4'b0101, 1'b0);
    cur_req = "R11";
    br(4'b1111, 8'h31, 8'h35, 8'h40); chk("R11", 8'h31, 4'b0101, 1'b0);
    cur_req = "R5";
    st(8'h40); chk("R5", 8'h22, 4'b1010, 1'b0);
    st(8'h23); chk("R5", 8'h23, 4'b1010, 1'b0);
    cur_req = "R6";
    st(8'h40); chk("R6", 8'h40, 4'b1111, 1'b0);

    cur_req = "R10";
    ev(1'b1, 4'b0000, 8'h77, 8'h41, 8'h70, 1'b1, 8'h55); chk("R10", 8'h41, 4'b1111, 1'b0);

    cur_req = "R7";
    br(4'b0011, 8'h50, 8'h60, 8'h60); chk("R7", 8'h50, 4'b0011, 1'b0);
    st(8'h60); chk("R7", 8'h60, 4'b1111, 1'b0);
    br(4'b0110, 8'h60, 8'h60, 8'h60); chk("R7", 8'h60, 4'b1111, 1'b0);

    cur_req = "R8";
    br(4'b1100, 8'h70, 8'h61, 8'h80); chk("R8", 8'h70, 4'b1100, 1'b0);
    br(4'b0100, 8'h72, 8'h71, 8'h80); chk("R8", 8'h72, 4'b0100, 1'b0);
    st(8'h80); chk("R8", 8'h71, 4'b1000, 1'b0);
    st(8'h80); chk("R8", 8'h61, 4'b0011, 1'b0);
    st(8'h80); chk("R8", 8'h80, 4'b1111, 1'b0);

    cur_req = "R12";
    st(8'h00); chk("R12", 8'h00, 4'b1111, 1'b0);
    st(8'h00); chk("R12", 8'h00, 4'b1111, 1'b0);

    cur_req = "R9";
    br(4'b1100, 8'h08, 8'h04, 8'h0C); chk("R9", 8'h08, 4'b1100, 1'b0);
    br(4'b1000, 8'h09, 8'h0A, 8'h0B); chk("R9", 8'h08, 4'b1100, 1'b1);
    st(8'h09); chk("R9", 8'h09, 4'b1100, 1'b1);
    st(8'h0C); chk("R9", 8'h04, 4'b0011, 1'b1);

    @(negedge clk);
    finish_run();
  end
endmodule